// File: doc/BRIEF.md
# Bit-Plane Corner-Turn Double Buffer

This block reorders pixel samples for a bank of distributed-arithmetic transform engines. Samples arrive one 9-bit word per cycle and fill an 8x8 block in raster order. On the output side the block gives one bit-plane per cycle. A bit-plane is a 64-bit vector that carries the same bit position of every sample in a block. The 64 engines can then each take one serial bit stream in parallel.

Two storage banks alternate. One bank fills while the other bank streams its nine planes. The banks trade roles only when the filling bank holds a whole block and the streaming bank has given out its last plane. Until that happens, the write side stalls by dropping its ready. After reset both banks are empty and the read side stays idle until the first block is complete.

Top module: `bitplane_turn_buf`

## Requirements
- R1: While reset is high and in the first cycle after reset, `wr_ready` is 1, `rd_valid` is 0, `rd_plane` is 0 and `rd_vec` is 0.
- R2: A sample is stored when `wr_valid` and `wr_ready` are both high at a rising clock edge. The n-th stored sample of a block (n = 0..63, raster address row*8+column) appears on bit n of `rd_vec`.
- R3: `wr_ready` drops in the cycle after the 64th sample of a block is stored. It stays low until the banks trade roles.
- R4: The banks trade roles at the first rising edge where the filling bank is full and the read side is idle. In the cycle after that edge, `rd_valid` is 1, `rd_plane` is 0 and `wr_ready` is 1 again.
- R5: A block is read in exactly 9 consecutive cycles with `rd_plane` going 0,1,...,8 (least significant bit first). In the cycle showing plane k, bit n of `rd_vec` equals bit k of sample n. `rd_valid` is 0 in the cycle after plane 8.
- R6: Whenever `rd_valid` is 0, `rd_plane` and `rd_vec` are 0.
- R7: Samples written while a block is being read go to the other bank. They do not change the planes of the block being read.
- R8: A write offered while `wr_ready` is low is dropped. It does not appear in any later block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | A sample is offered on `wr_data` |
| wr_data | input | 9 | Sample word |
| wr_ready | output | 1 | The filling bank can take a sample |
| rd_valid | output | 1 | `rd_vec` carries a valid bit-plane |
| rd_plane | output | 4 | Bit position of the plane on `rd_vec` |
| rd_vec | output | 64 | Bit `rd_plane` of each of the 64 samples, sample n on bit n |

## Verification
The properties assume that reset is applied before any check and that `wr_valid` may be high in any cycle, including stall cycles. No protocol is assumed on the write side. The read side has no backpressure, so the properties only assume the plane sequence the block produces itself. The stimulus mixes several kinds of traffic: steady writes, bursty writes with random gaps, writes that keep being offered while the bank is full, and samples at the extremes 0, 0x100 and 0x1FF. This shows both the stall rule and the bank separation at the ports.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
    localparam int SAMPLE_W  = 9;
    localparam int BLK_SIDE  = 8;
    localparam int BLK_WORDS = BLK_SIDE * BLK_SIDE;
    localparam int ADDR_W    = $clog2(BLK_WORDS);
    localparam int SIDE_W    = $clog2(BLK_SIDE);
    localparam int PLANE_W   = $clog2(SAMPLE_W);
    localparam int NUM_BANKS = 2;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [BLK_WORDS-1:0] plane_vec_t;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    typedef struct packed {
        logic              en;
        bank_e             bank;
        logic [ADDR_W-1:0] addr;
        sample_t           data;
    } wr_req_t;

    typedef struct packed {
        logic               en;
        bank_e              bank;
        logic [PLANE_W-1:0] plane;
    } rd_req_t;

    function automatic bank_e other_bank(input bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

    function automatic logic [ADDR_W-1:0] raster_addr(input logic [SIDE_W-1:0] row,
                                                      input logic [SIDE_W-1:0] col);
        return ADDR_W'(row) * ADDR_W'(BLK_SIDE) + ADDR_W'(col);
    endfunction
endpackage

// File: rtl/bpt_fill_ctrl.sv
module bpt_fill_ctrl
    import bpt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    wr_valid,
    input  sample_t wr_data,
    input  bank_e   fill_bank,
    input  logic    swap,
    output logic    wr_ready,
    output logic    full,
    output wr_req_t req
);
    logic [SIDE_W-1:0] row_q, col_q;
    logic              full_q;
    logic              accept;

    localparam logic [SIDE_W-1:0] LAST_IDX = SIDE_W'(BLK_SIDE - 1);

    assign accept   = wr_valid && !full_q;
    assign wr_ready = !full_q;
    assign full     = full_q;

    always_comb begin
        req.en   = accept;
        req.bank = fill_bank;
        req.addr = raster_addr(row_q, col_q);
        req.data = wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            col_q  <= '0;
            full_q <= 1'b0;
        end else if (swap) begin
            row_q  <= '0;
            col_q  <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            if (col_q == LAST_IDX) begin
                col_q <= '0;
                if (row_q == LAST_IDX) begin
                    row_q  <= '0;
                    full_q <= 1'b1;
                end else begin
                    row_q <= row_q + 1'b1;
                end
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpt_plane_seq.sv
module bpt_plane_seq
    import bpt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    output logic               busy,
    output logic [PLANE_W-1:0] plane
);
    localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(SAMPLE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            plane <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            plane <= '0;
        end else if (busy) begin
            if (plane == LAST_PLANE) begin
                busy  <= 1'b0;
                plane <= '0;
            end else begin
                plane <= plane + 1'b1;
            end
        end
    end
endmodule

// File: rtl/bpt_bank_pair.sv
module bpt_bank_pair
    import bpt_pkg::*;
(
    input  logic       clk,
    input  wr_req_t    wr,
    input  rd_req_t    rd,
    output plane_vec_t vec
);
    plane_vec_t bank_vec [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sample_t store [BLK_WORDS];

        always_ff @(posedge clk) begin
            if (wr.en && (wr.bank == bank_e'(b)))
                store[wr.addr] <= wr.data;
        end

        always_comb begin
            for (int n = 0; n < BLK_WORDS; n++)
                bank_vec[b][n] = store[n][rd.plane];
        end
    end

    always_comb begin
        if (rd.en)
            vec = bank_vec[rd.bank];
        else
            vec = '0;
    end
endmodule

// File: rtl/bitplane_turn_buf.sv
module bitplane_turn_buf
    import bpt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic                wr_ready,
    output logic                rd_valid,
    output logic [PLANE_W-1:0]  rd_plane,
    output logic [BLK_WORDS-1:0] rd_vec
);
    bank_e              fill_bank_q;
    logic               full;
    logic               busy;
    logic               swap;
    logic [PLANE_W-1:0] plane;
    wr_req_t            wreq;
    rd_req_t            rreq;

    assign swap = full && !busy;

    always_ff @(posedge clk) begin
        if (rst)
            fill_bank_q <= BANK_A;
        else if (swap)
            fill_bank_q <= other_bank(fill_bank_q);
    end

    bpt_fill_ctrl u_fill (
        .clk       (clk),
        .rst       (rst),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .fill_bank (fill_bank_q),
        .swap      (swap),
        .wr_ready  (wr_ready),
        .full      (full),
        .req       (wreq)
    );

    bpt_plane_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (swap),
        .busy  (busy),
        .plane (plane)
    );

    always_comb begin
        rreq.en    = busy;
        rreq.bank  = other_bank(fill_bank_q);
        rreq.plane = plane;
    end

    bpt_bank_pair u_banks (
        .clk (clk),
        .wr  (wreq),
        .rd  (rreq),
        .vec (rd_vec)
    );

    assign rd_valid = busy;
    assign rd_plane = busy ? plane : '0;
endmodule

// File: rtl/bitplane_turn_buf_chk.sv
module bitplane_turn_buf_chk
    import bpt_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_ready,
    input logic                 rd_valid,
    input logic [PLANE_W-1:0]   rd_plane,
    input logic [BLK_WORDS-1:0] rd_vec
);
    localparam logic [PLANE_W-1:0] LAST_PLANE = PLANE_W'(SAMPLE_W - 1);

    p_plane_step_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_plane != LAST_PLANE) |=> (rd_valid && rd_plane == $past(rd_plane) + 1'b1));

    p_read_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_plane == LAST_PLANE) |=> !rd_valid);

    p_start_plane_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |-> (rd_plane == '0 && wr_ready));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_plane == '0 && rd_vec == '0));

    p_stall_swaps_r3: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && !rd_valid) |=> rd_valid);

    p_plane_range_r5: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_plane <= LAST_PLANE));
endmodule

bind bitplane_turn_buf bitplane_turn_buf_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_ready (wr_ready),
    .rd_valid (rd_valid),
    .rd_plane (rd_plane),
    .rd_vec   (rd_vec)
);

// File: tb/bitplane_turn_buf_bench.sv
module bitplane_turn_buf_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_valid = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        wr_ready;
    logic        rd_valid;
    logic [3:0]  rd_plane;
    logic [63:0] rd_vec;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    int  m_fill[$];
    int  m_blk[64];
    bit  m_busy = 0;
    int  m_plane = 0;
    string vec_tag = "R2";

    always #4 clk = ~clk;

    bitplane_turn_buf u_bitplane_turn_buf (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_plane(rd_plane), .rd_vec(rd_vec)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [63:0] exp_vec();
        logic [63:0] v = '0;
        if (m_busy)
            for (int n = 0; n < 64; n++) v[n] = m_blk[n][m_plane];
        return v;
    endfunction

    task automatic compare();
        string tag_v;
        tag_v = (m_busy && m_plane == 0) ? "R4" : "R6";
        chk("R3", {63'd0, wr_ready}, {63'd0, m_fill.size() < 64});
        chk(tag_v, {63'd0, rd_valid}, {63'd0, m_busy});
        chk("R5", {60'd0, rd_plane}, m_busy ? 64'(m_plane) : 64'd0);
        chk(vec_tag, rd_vec, exp_vec());
    endtask

    // drive inputs for the coming edge, advance the model, then sample at the negedge
    task automatic cycle(input bit v, input logic [8:0] d);
        bit acc, sw;
        wr_valid = v;
        wr_data  = d;
        acc = v && (m_fill.size() < 64);
        sw  = (m_fill.size() == 64) && !m_busy;
        if (sw) begin
            for (int n = 0; n < 64; n++) m_blk[n] = m_fill[n];
            m_fill.delete();
            m_busy  = 1;
            m_plane = 0;
        end else if (m_busy) begin
            if (m_plane == 8) begin
                m_busy  = 0;
                m_plane = 0;
            end else begin
                m_plane++;
            end
        end
        if (acc) m_fill.push_back(int'(d));
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        chk("R1", {63'd0, wr_ready}, 64'd1);
        chk("R1", {63'd0, rd_valid}, 64'd0);
        chk("R1", {60'd0, rd_plane}, 64'd0);
        chk("R1", rd_vec, 64'd0);
        rst = 1'b0;

        // R2: one block with a ramp plus extreme values, then drain
        vec_tag = "R2";
        for (int i = 0; i < 64; i++) begin
            logic [8:0] d;
            d = (i == 5) ? 9'h1FF : (i == 6) ? 9'h100 : (i == 7) ? 9'h000 : 9'((i * 37) % 512);
            cycle(1'b1, d);
        end
        for (int i = 0; i < 16; i++) cycle(1'b0, 9'h0);

        // R7: continuous writes so the next block fills during every read
        vec_tag = "R7";
        for (int i = 0; i < 400; i++) cycle(1'b1, 9'($urandom));

        // R8: bursty writes; data keeps changing while ready is low
        vec_tag = "R8";
        for (int i = 0; i < 600; i++) cycle(($urandom % 3) != 0, 9'($urandom));
        for (int i = 0; i < 200; i++) cycle(1'b1, (i % 2 == 0) ? 9'h1FF : 9'h000);
        for (int i = 0; i < 30; i++) cycle(1'b0, 9'h0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R5 watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule